// File: doc/BRIEF.md
# Paired Hash Chain Builder

This block builds the candidate chains that a dictionary compressor walks when it looks for earlier copies of the bytes at the current position. A byte stream arrives two bytes per beat. Each position is named by a hash of its own byte and the two bytes after it. For every position the block reads the newest position stored for that hash, writes that value into the link table at the current position, and then makes the current position the newest entry for the hash. Following the links from any position visits every earlier position with the same hash, newest first, until the all-ones end marker is reached.

Two consecutive positions go through a five-stage pipeline together: beat capture, hash, newest-entry read, link write and newest-entry write. Both tables are split into an even bank and an odd bank. The newest-entry table is banked by hash bit 0 and the link table by position bit 0, so the two positions of a pair never compete for a link bank. They do compete for a newest-entry bank when their hashes differ but share bit 0. In that case the pair is issued as two single positions on consecutive cycles, and the input takes one cycle of back-pressure. Writes that are still in flight are forwarded to later reads of the same hash, so the tables always end up as if positions had been inserted one at a time in order.

A segment is opened with `start` and `start_pos`, fed beats until one is marked last, and is complete when `done` rises. The stream is valid/ready: a beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold the beat stable while `in_ready` is low. `in_ready` only drops for idle periods and for the single cycle taken by a bank split. `start` must be given only after reset or while `done` is high. Two lookup ports return the newest position for a hash and the link stored at a position, so a chain walker can use the tables.

Top module: `hash_chain_inserter`

## Requirements
- R1: The hash of position p is ((b[p] << 6) ^ (b[p+1] << 3) ^ b[p+2]) truncated to 8 bits, where b[p] is the byte at position p. In each beat, `in_data[7:0]` is the earlier byte and `in_data[15:8]` is the later one.
- R2: For each inserted position p with hash h, link[p] receives the newest position held for h, and then the newest position for h becomes p. At `done`, both tables equal the result of inserting positions one at a time in increasing order.
- R3: After reset, every newest-entry slot holds the end marker 10'h3FF (all ones). A position whose hash has no earlier occurrence gets 10'h3FF as its link.
- R4: A segment of N beats starting at S inserts positions S through S+2N-3. The two positions of the last beat are not inserted, because the bytes after them never arrive. A segment of one beat inserts nothing.
- R5: A pair whose two hashes differ but share hash bit 0 holds `in_ready` low for exactly one cycle. For a segment of N ≥ 2 beats sent without gaps, `done` becomes visible N+4+K clock edges after the edge that accepts the first beat, where K is the number of such pairs.
- R6: When both positions of a pair have the same hash, the later position's link is the earlier position, the newest entry becomes the later position, and no stall is taken.
- R7: `in_ready` is low after reset until `start`, and low from the edge that accepts the last beat. `done` is low after reset, drops after `start`, and is high once every write of the segment has landed.
- R8: The lookup ports are registered. The values for `head_lk_hash` and `prev_lk_pos` appear on `head_lk_pos` and `prev_lk_link` one clock edge after the address is applied.
- R9: `start` clears neither table, so chains run on across segments.
- R10: When a hash is reused by back-to-back pairs, the newer pair sees the older pair's position even though that write has not yet reached the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a segment |
| start_pos | input | 10 | Position of the first byte of the segment |
| in_valid | input | 1 | Beat present |
| in_data | input | 16 | Two bytes; the low byte is the earlier one |
| in_last | input | 1 | Marks the final beat of the segment |
| in_ready | output | 1 | Beat accepted at the next edge when in_valid is high |
| done | output | 1 | Segment fully written into the tables |
| head_lk_hash | input | 8 | Hash whose newest position is looked up |
| head_lk_pos | output | 10 | Newest position for the looked-up hash |
| prev_lk_pos | input | 10 | Position whose link is looked up |
| prev_lk_link | output | 10 | Link stored at the looked-up position |

## Verification
On every cycle the assertions check several properties. A pair issued in one piece never puts two different hashes on the same newest-entry bank. A split always issues its second half on the next cycle. A same-hash pair links its later position to its earlier one. A hash reused by back-to-back pairs picks up the older position from the pipeline. The input closes after the last beat. The link writes of a pair always go to opposite banks. Only the bench scenarios can show that the final tables match one-at-a-time insertion across random, constant, periodic, odd-start and one-beat segments, that chains carry over between segments, and that each bank split costs exactly one cycle in the time to `done`.

// File: rtl/hchain_pkg.sv
package hchain_pkg;
  parameter int POS_W      = 10;
  parameter int HASH_W     = 8;
  parameter int HASH_SHIFT = 3;
  parameter int LANES      = 2;

  localparam int HBANK_AW = HASH_W - 1;
  localparam int PBANK_AW = POS_W - 1;
  localparam int BEAT_W   = 8 * LANES;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [HASH_W-1:0] hash_t;

  localparam pos_t NULL_POS = '1;
  localparam pos_t POS_ONE  = pos_t'(1);
  localparam pos_t POS_STEP = pos_t'(LANES);

  // lane bundle that travels down the pipe
  typedef struct packed {
    logic  [LANES-1:0] v;
    pos_t  [LANES-1:0] pos;
    hash_t [LANES-1:0] hash;
  } hop_t;

  // bundle plus the resolved previous-newest value per lane
  typedef struct packed {
    hop_t             core;
    pos_t [LANES-1:0] old;
  } op_t;

  function automatic hash_t hash3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [31:0] x;
    x = ({24'b0, a} << (2 * HASH_SHIFT)) ^ ({24'b0, b} << HASH_SHIFT) ^ {24'b0, c};
    return x[HASH_W-1:0];
  endfunction

  // newest lane of an in-flight bundle carrying hash h; bit POS_W flags a hit
  function automatic logic [POS_W:0] newest_hit(hop_t o, hash_t h);
    logic [POS_W:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) begin
      if (o.v[l] && o.hash[l] == h) r = {1'b1, o.pos[l]};
    end
    return r;
  endfunction
endpackage

// File: rtl/hchain_front.sv
module hchain_front
  import hchain_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  pos_t                     start_pos,
  input  logic                     in_valid,
  input  logic [BEAT_W-1:0]        in_data,
  input  logic                     in_last,
  output logic                     in_ready,
  output logic [LANES-1:0]         iss_v,
  output pos_t  [LANES-1:0]        iss_pos,
  output hash_t [LANES-1:0]        iss_hash,
  output logic                     busy
);
  logic              active;
  pos_t              cur_pos;
  logic [BEAT_W-1:0] hold;
  logic              hold_v;

  // stage 1: four bytes covering both positions of a pair
  logic                s1_v;
  logic [2*BEAT_W-1:0] s1_bytes;
  pos_t                s1_pos;

  // stage 2: hashes
  logic                s2_v;
  pos_t                s2_pos;
  hash_t [LANES-1:0]   s2_hash;
  logic                half;

  logic conflict, stall, accept;

  assign conflict = s2_v && (s2_hash[0][0] == s2_hash[1][0]) && (s2_hash[0] != s2_hash[1]);
  assign stall    = conflict && !half;
  assign in_ready = active && !stall;
  assign accept   = in_valid && in_ready;
  assign busy     = active || s1_v || s2_v;

  always_comb begin
    iss_pos[0]  = s2_pos;
    iss_pos[1]  = s2_pos + POS_ONE;
    iss_hash    = s2_hash;
    if (!s2_v)          iss_v = 2'b00;
    else if (!conflict) iss_v = 2'b11;
    else if (!half)     iss_v = 2'b01;
    else                iss_v = 2'b10;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_pos  <= '0;
      hold     <= '0;
      hold_v   <= 1'b0;
      s1_v     <= 1'b0;
      s1_bytes <= '0;
      s1_pos   <= '0;
      s2_v     <= 1'b0;
      s2_pos   <= '0;
      s2_hash  <= '0;
      half     <= 1'b0;
    end else begin
      if (start) begin
        active  <= 1'b1;
        cur_pos <= start_pos;
        hold_v  <= 1'b0;
      end else if (accept) begin
        hold   <= in_data;
        hold_v <= !in_last;
        if (in_last) active <= 1'b0;
        if (hold_v)  cur_pos <= cur_pos + POS_STEP;
      end
      half <= stall;
      if (!stall) begin
        s1_v     <= accept && hold_v;
        s1_bytes <= {in_data, hold};
        s1_pos   <= cur_pos;
        s2_v     <= s1_v;
        s2_pos   <= s1_pos;
        s2_hash[0] <= hash3(s1_bytes[7:0],  s1_bytes[15:8],  s1_bytes[23:16]);
        s2_hash[1] <= hash3(s1_bytes[15:8], s1_bytes[23:16], s1_bytes[31:24]);
      end
    end
  end
endmodule

// File: rtl/hchain_head_bank.sv
module hchain_head_bank
  import hchain_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HBANK_AW-1:0] rd_addr,
  output pos_t                rd_data,
  input  logic                we,
  input  logic [HBANK_AW-1:0] wr_addr,
  input  pos_t                wr_data,
  input  logic [HBANK_AW-1:0] lk_addr,
  output pos_t                lk_data
);
  localparam int DEPTH = 1 << HBANK_AW;
  pos_t mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= NULL_POS;
      lk_data <= NULL_POS;
    end else begin
      if (we) mem[wr_addr] <= wr_data;
      lk_data <= mem[lk_addr];
    end
  end
endmodule

// File: rtl/hchain_prev_bank.sv
module hchain_prev_bank
  import hchain_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PBANK_AW-1:0] wr_addr,
  input  pos_t                wr_data,
  input  logic [PBANK_AW-1:0] lk_addr,
  output pos_t                lk_data
);
  localparam int DEPTH = 1 << PBANK_AW;
  pos_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lk_data <= NULL_POS;
    else        lk_data <= mem[lk_addr];
  end
endmodule

// File: rtl/hash_chain_inserter.sv
module hash_chain_inserter
  import hchain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [POS_W-1:0]  start_pos,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              done,
  input  logic [HASH_W-1:0] head_lk_hash,
  output logic [POS_W-1:0]  head_lk_pos,
  input  logic [POS_W-1:0]  prev_lk_pos,
  output logic [POS_W-1:0]  prev_lk_link
);
  logic [LANES-1:0]  fr_iss_v;
  pos_t  [LANES-1:0] fr_iss_pos;
  hash_t [LANES-1:0] fr_iss_hash;
  logic              fr_busy;

  hchain_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_pos(start_pos),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .iss_v    (fr_iss_v),
    .iss_pos  (fr_iss_pos),
    .iss_hash (fr_iss_hash),
    .busy     (fr_busy)
  );

  op_t  iss, s3, s4;
  hop_t s5;
  logic armed;
  logic head_sel_q, prev_sel_q;

  logic [HBANK_AW-1:0] hrd_addr [2];
  pos_t                hrd_data [2];
  logic                hwe      [2];
  logic [HBANK_AW-1:0] hwa      [2];
  pos_t                hwd      [2];
  pos_t                hlk      [2];
  logic                pwe      [2];
  logic [PBANK_AW-1:0] pwa      [2];
  pos_t                pwd      [2];
  pos_t                plk      [2];

  logic s5_w0, s5_w1;
  assign s5_w1 = s5.v[1];
  assign s5_w0 = s5.v[0] && !(s5.v[1] && s5.hash[0] == s5.hash[1]);

  // stage 3 input: read, forward from in-flight bundles, then in-pair link
  always_comb begin
    iss.core.v    = fr_iss_v;
    iss.core.pos  = fr_iss_pos;
    iss.core.hash = fr_iss_hash;
    for (int l = 0; l < LANES; l++) begin
      logic [POS_W:0] f3, f4, f5;
      f3 = newest_hit(s3.core, fr_iss_hash[l]);
      f4 = newest_hit(s4.core, fr_iss_hash[l]);
      f5 = newest_hit(s5, fr_iss_hash[l]);
      if (f3[POS_W])      iss.old[l] = f3[POS_W-1:0];
      else if (f4[POS_W]) iss.old[l] = f4[POS_W-1:0];
      else if (f5[POS_W]) iss.old[l] = f5[POS_W-1:0];
      else                iss.old[l] = hrd_data[fr_iss_hash[l][0]];
    end
    if (fr_iss_v == 2'b11 && fr_iss_hash[0] == fr_iss_hash[1])
      iss.old[1] = fr_iss_pos[0];
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BSEL = (b == 1);
    logic h0_here, h1_here, p0_here, p1_here;

    assign h0_here = s5_w0 && (s5.hash[0][0] == BSEL);
    assign h1_here = s5_w1 && (s5.hash[1][0] == BSEL);
    assign p0_here = s4.core.v[0] && (s4.core.pos[0][0] == BSEL);
    assign p1_here = s4.core.v[1] && (s4.core.pos[1][0] == BSEL);

    assign hrd_addr[b] = (fr_iss_v[0] && fr_iss_hash[0][0] == BSEL)
                         ? fr_iss_hash[0][HASH_W-1:1] : fr_iss_hash[1][HASH_W-1:1];
    assign hwe[b] = h0_here || h1_here;
    assign hwa[b] = h0_here ? s5.hash[0][HASH_W-1:1] : s5.hash[1][HASH_W-1:1];
    assign hwd[b] = h0_here ? s5.pos[0] : s5.pos[1];
    assign pwe[b] = p0_here || p1_here;
    assign pwa[b] = p0_here ? s4.core.pos[0][POS_W-1:1] : s4.core.pos[1][POS_W-1:1];
    assign pwd[b] = p0_here ? s4.old[0] : s4.old[1];

    hchain_head_bank u_head (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(hrd_addr[b]),
      .rd_data(hrd_data[b]),
      .we     (hwe[b]),
      .wr_addr(hwa[b]),
      .wr_data(hwd[b]),
      .lk_addr(head_lk_hash[HASH_W-1:1]),
      .lk_data(hlk[b])
    );

    hchain_prev_bank u_prev (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (pwe[b]),
      .wr_addr(pwa[b]),
      .wr_data(pwd[b]),
      .lk_addr(prev_lk_pos[POS_W-1:1]),
      .lk_data(plk[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3         <= '0;
      s4         <= '0;
      s5         <= '0;
      armed      <= 1'b0;
      head_sel_q <= 1'b0;
      prev_sel_q <= 1'b0;
    end else begin
      s3         <= iss;
      s4         <= s3;
      s5         <= s4.core;
      head_sel_q <= head_lk_hash[0];
      prev_sel_q <= prev_lk_pos[0];
      if (start) armed <= 1'b1;
    end
  end

  assign head_lk_pos  = hlk[head_sel_q];
  assign prev_lk_link = plk[prev_sel_q];
  assign done = armed && !fr_busy && (s3.core.v == '0) && (s4.core.v == '0) && (s5.v == '0);
endmodule

// File: rtl/hchain_checker.sv
module hchain_checker
  import hchain_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              in_ready,
  input logic              in_valid,
  input logic              in_last,
  input logic [LANES-1:0]  iss_v,
  input hash_t [LANES-1:0] iss_hash,
  input op_t               s3,
  input op_t               s4
);
  a_r5_one_bank_per_hash: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_v == 2'b11 && iss_hash[0] != iss_hash[1]) |-> (iss_hash[0][0] != iss_hash[1][0]));

  a_r5_split_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_v == 2'b01) |=> (iss_v == 2'b10));

  a_r6_pair_self_link: assert property (@(posedge clk) disable iff (!rst_n)
    (s3.core.v == 2'b11 && s3.core.hash[0] == s3.core.hash[1]) |-> (s3.old[1] == s3.core.pos[0]));

  a_r10_pipe_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (s3.core.v[0] && s4.core.v[1] && s4.core.hash[1] == s3.core.hash[0]) |-> (s3.old[0] == s4.core.pos[1]));

  a_r2_link_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (s4.core.v == 2'b11) |-> (s4.core.pos[0][0] != s4.core.pos[1][0]));

  a_r7_done_closes_input: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  a_r4_last_closes_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind hash_chain_inserter hchain_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .in_ready(in_ready),
  .in_valid(in_valid),
  .in_last (in_last),
  .iss_v   (fr_iss_v),
  .iss_hash(fr_iss_hash),
  .s3      (s3),
  .s4      (s4)
);

// File: tb/hash_chain_inserter_test.sv
module hash_chain_inserter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] start_pos = '0;
  logic       in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready, done;
  logic [7:0] head_lk_hash = '0;
  logic [9:0] head_lk_pos;
  logic [9:0] prev_lk_pos = '0;
  logic [9:0] prev_lk_link;

  hash_chain_inserter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pos(start_pos),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .done(done), .head_lk_hash(head_lk_hash), .head_lk_pos(head_lk_pos),
    .prev_lk_pos(prev_lk_pos), .prev_lk_link(prev_lk_link)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int ec = 0;
  bit finished = 0;
  int ref_head [256];
  int ref_prev [1024];
  bit ref_set  [1024];
  logic [7:0] bytes [64];

  always @(posedge clk) ec <= ec + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hsh(int a, int b, int c);
    return ((a << 6) ^ (b << 3) ^ c) & 255;
  endfunction

  task automatic compare_tables(string tag);
    for (int h = 0; h < 256; h++) begin
      head_lk_hash = h[7:0];
      @(negedge clk);
      check(int'(head_lk_pos) == ref_head[h], tag, int'(head_lk_pos), ref_head[h]);
    end
    for (int p = 0; p < 1024; p++) begin
      if (ref_set[p]) begin
        prev_lk_pos = p[9:0];
        @(negedge clk);
        check(int'(prev_lk_link) == ref_prev[p], tag, int'(prev_lk_link), ref_prev[p]);
      end
    end
  endtask

  // mode 0 random, 1 constant, 2 period three
  task automatic run_segment(int sp, int nb, int mode, string tag);
    int conf = 0;
    int ec0 = 0;
    for (int i = 0; i < 2 * nb; i++) begin
      case (mode)
        0: bytes[i] = 8'($urandom);
        1: bytes[i] = 8'h41;
        default: bytes[i] = (i % 3 == 0) ? 8'h10 : ((i % 3 == 1) ? 8'h27 : 8'h3c);
      endcase
    end
    // sequential reference insertion (R1, R2, R4)
    for (int p = 0; p + 2 < 2 * nb; p++) begin
      int h = hsh(bytes[p], bytes[p+1], bytes[p+2]);
      ref_prev[sp + p] = ref_head[h];
      ref_set[sp + p]  = 1;
      ref_head[h]      = sp + p;
    end
    for (int j = 0; j + 1 < nb; j++) begin
      int h0 = hsh(bytes[2*j], bytes[2*j+1], bytes[2*j+2]);
      int h1 = hsh(bytes[2*j+1], bytes[2*j+2], bytes[2*j+3]);
      if (h0 != h1 && (h0 & 1) == (h1 & 1)) conf++;
    end
    start = 1'b1;
    start_pos = sp[9:0];
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7 done low after start", int'(done), 0);
    for (int k = 0; k < nb; k++) begin
      in_valid = 1'b1;
      in_data  = {bytes[2*k+1], bytes[2*k]};
      in_last  = (k == nb - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (k == 0) ec0 = ec;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(in_ready == 1'b0, "R7 ready low after last", int'(in_ready), 0);
    while (!done) @(negedge clk);
    if (nb >= 2)
      check(ec - ec0 == nb + 4 + conf, "R5 cycles to done", ec - ec0, nb + 4 + conf);
    compare_tables(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_head[i] = 1023;
    for (int i = 0; i < 1024; i++) begin
      ref_prev[i] = 1023;
      ref_set[i]  = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R7 done after reset", int'(done), 0);
    check(in_ready == 1'b0, "R7 ready before start", int'(in_ready), 0);
    compare_tables("R3 R8 reset table");
    run_segment(0,   20, 0, "R1 R2 random");
    run_segment(40,  16, 1, "R6 R10 constant");
    run_segment(80,  24, 0, "R2 R5 random");
    run_segment(131, 30, 0, "R2 R4 odd start");
    run_segment(200, 1,  0, "R4 single beat");
    run_segment(202, 10, 2, "R9 R10 period three");
    run_segment(230, 32, 0, "R9 random carry");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule